// File: doc/BRIEF.md
# Real-Time Transmit QoS Arbiter

This block decides which of two transmit queues may launch the next Ethernet frame. One queue holds real-time frames, which are scheduled against a launch time stamp. The other holds ordinary, low-priority frames. The transmitter sends one frame at a time. Each time it goes idle, the arbiter looks at the two head-of-queue requests, raises a one-hot grant and gives a one-cycle start strobe. The grant stays up until the MAC reports that the frame is complete.

When quality-of-service arbitration is switched on, two mechanisms shape the choice. The first is a guard interval ahead of the next real-time launch time. While the distance from the free-running transmit time to that launch stamp is below a programmed margin, low-priority frames may not start, so the medium stays free for the real-time frame. The second is an ageing timer. It counts in steps of 64 clocks, starts when a low-priority frame reaches the head of its queue, and promotes that frame above all other traffic once it expires. When arbitration is switched off, the two queues simply take turns, and neither mechanism has any effect.

Top module: `qos_tx_arbiter`

## Requirements
- R1: During and after reset, `grant` is 0 and `start_pulse` is 0 until a request is granted.
- R2: `grant` is one-hot or zero, with bit 0 for the real-time queue and bit 1 for the low-priority queue. It rises one clock after an idle-cycle decision and holds until the cycle after `tx_done`. `start_pulse` is high only in the first cycle of each grant.
- R3: With `qos_en` low and both queues requesting, grants alternate between the queues, starting with real-time after reset. The guard interval and the ageing timer have no effect in this mode.
- R4: With `qos_en` high, a pending real-time request wins over a low-priority request that has not aged.
- R5: With `qos_en` high, a low-priority frame that has not aged does not start while `(rt_launch - tx_time) mod 2^16` is strictly less than `block_zone`. It may start once that distance equals or exceeds `block_zone`.
- R6: A `block_zone` of 0 never holds back low-priority frames.
- R7: Once a low-priority request has waited `age_limit` x 64 clocks at the head of its queue, it is granted ahead of a pending real-time request. The wait time resets when that frame starts.
- R8: An aged low-priority frame starts even while the guard interval is active.
- R9: An `age_limit` of 0 promotes a low-priority request at once.
- R10: While a grant is held, no new start occurs and the grant does not change, whatever the requests do.
- R11: No grant is given to a queue that is not requesting. With no requests, nothing starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock |
| rst | input | 1 | Synchronous active-high reset |
| qos_en | input | 1 | Enables priority, guard interval and ageing |
| rt_req | input | 1 | Real-time queue has a frame at its head |
| nrt_req | input | 1 | Low-priority queue has a frame at its head |
| tx_done | input | 1 | MAC reports the granted frame complete |
| tx_time | input | 16 | Free-running transmit time counter |
| rt_launch | input | 16 | Launch time stamp of the next real-time frame |
| block_zone | input | 16 | Guard margin before the launch stamp, 0 disables it |
| age_limit | input | 16 | Ageing limit in units of 64 clocks |
| grant | output | 2 | One-hot grant: bit 0 real-time, bit 1 low-priority |
| start_pulse | output | 1 | One-cycle strobe for the first cycle of a grant |

## Verification
The arbiter decides at the first clock edge on which it is idle with a request present. Grant and start strobe then appear together one clock later, and the grant falls one clock after the edge that samples `tx_done`. The bench changes inputs and samples outputs on the falling edge. A monitor compares each start strobe against the queue entry that the stimulus pushed, so order is checked without fixing a cycle, and a start with nothing queued is an error. Guard-interval and ageing cases use wait windows far from the 64-clock tick boundaries. One clock of uncertainty in the prescaler phase therefore cannot change the expected winner.

// File: rtl/qos_arb_pkg.sv
package qos_arb_pkg;

    localparam int GNT_W   = 2;
    localparam int GNT_RT  = 0;
    localparam int GNT_NRT = 1;

    typedef logic [GNT_W-1:0] gnt_t;

    typedef enum logic {
        ARB_IDLE = 1'b0,
        ARB_BUSY = 1'b1
    } arb_state_e;

    typedef struct packed {
        logic vld;
        gnt_t sel;
    } arb_pick_t;

    function automatic gnt_t gnt_of(input logic pick_nrt);
        gnt_t g;
        g = '0;
        g[pick_nrt ? GNT_NRT : GNT_RT] = 1'b1;
        return g;
    endfunction

endpackage

// File: rtl/qos_age_timer.sv
module qos_age_timer #(
    parameter int CW       = 16,
    parameter int DIV_LOG2 = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          nrt_req,
    input  logic          nrt_start,
    input  logic [CW-1:0] limit,
    output logic          aged
);
    localparam logic [DIV_LOG2-1:0] PRE_LAST = '1;

    logic                tracking;
    logic [DIV_LOG2-1:0] pre;
    logic [CW-1:0]       cnt;
    logic                tick;

    assign tick = (pre == PRE_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            tracking <= 1'b0;
            pre      <= '0;
            cnt      <= '0;
        end else if (nrt_start || !nrt_req) begin
            tracking <= 1'b0;
            pre      <= '0;
        end else if (!tracking) begin
            tracking <= 1'b1;
            pre      <= '0;
            cnt      <= limit;
        end else begin
            pre <= pre + 1'b1;
            if (tick && cnt != '0)
                cnt <= cnt - 1'b1;
        end
    end

    assign aged = nrt_req && (tracking ? (cnt == '0) : (limit == '0));
endmodule

// File: rtl/qos_block_window.sv
module qos_block_window #(
    parameter int TW = 16,
    parameter int CW = 16
) (
    input  logic [TW-1:0] now,
    input  logic [TW-1:0] launch,
    input  logic [CW-1:0] zone,
    output logic          blocked
);
    localparam int XW = (TW > CW) ? TW : CW;

    logic [TW-1:0] lead;
    logic [XW-1:0] lead_x;
    logic [XW-1:0] zone_x;

    assign lead    = launch - now;
    assign lead_x  = XW'(lead);
    assign zone_x  = XW'(zone);
    assign blocked = lead_x < zone_x;
endmodule

// File: rtl/qos_pick.sv
module qos_pick
    import qos_arb_pkg::*;
(
    input  logic      qos_en,
    input  logic      rt_req,
    input  logic      nrt_req,
    input  logic      blocked,
    input  logic      aged,
    input  logic      last_nrt,
    output arb_pick_t pick
);
    always_comb begin
        pick = '0;
        if (!qos_en) begin
            if (rt_req && nrt_req)
                pick = '{vld: 1'b1, sel: gnt_of(!last_nrt)};
            else if (rt_req || nrt_req)
                pick = '{vld: 1'b1, sel: gnt_of(nrt_req)};
        end else begin
            if (nrt_req && aged)
                pick = '{vld: 1'b1, sel: gnt_of(1'b1)};
            else if (rt_req)
                pick = '{vld: 1'b1, sel: gnt_of(1'b0)};
            else if (nrt_req && !blocked)
                pick = '{vld: 1'b1, sel: gnt_of(1'b1)};
        end
    end
endmodule

// File: rtl/qos_tx_arbiter.sv
module qos_tx_arbiter
    import qos_arb_pkg::*;
#(
    parameter int TW       = 16,
    parameter int CW       = 16,
    parameter int DIV_LOG2 = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          qos_en,
    input  logic          rt_req,
    input  logic          nrt_req,
    input  logic          tx_done,
    input  logic [TW-1:0] tx_time,
    input  logic [TW-1:0] rt_launch,
    input  logic [CW-1:0] block_zone,
    input  logic [CW-1:0] age_limit,
    output logic [1:0]    grant,
    output logic          start_pulse
);
    arb_state_e state;
    gnt_t       grant_q;
    logic       start_q;
    logic       last_nrt;
    logic       blocked_w;
    logic       aged_w;
    logic       nrt_start;
    arb_pick_t  pick;

    qos_block_window #(.TW(TW), .CW(CW)) u_win (
        .now    (tx_time),
        .launch (rt_launch),
        .zone   (block_zone),
        .blocked(blocked_w)
    );

    assign nrt_start = (state == ARB_IDLE) && pick.vld && pick.sel[GNT_NRT];

    qos_age_timer #(.CW(CW), .DIV_LOG2(DIV_LOG2)) u_age (
        .clk      (clk),
        .rst      (rst),
        .nrt_req  (nrt_req),
        .nrt_start(nrt_start),
        .limit    (age_limit),
        .aged     (aged_w)
    );

    qos_pick u_pick (
        .qos_en  (qos_en),
        .rt_req  (rt_req),
        .nrt_req (nrt_req),
        .blocked (blocked_w),
        .aged    (aged_w),
        .last_nrt(last_nrt),
        .pick    (pick)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ARB_IDLE;
            grant_q  <= '0;
            start_q  <= 1'b0;
            last_nrt <= 1'b1;
        end else begin
            start_q <= 1'b0;
            unique case (state)
                ARB_IDLE: if (pick.vld) begin
                    state    <= ARB_BUSY;
                    grant_q  <= pick.sel;
                    start_q  <= 1'b1;
                    last_nrt <= pick.sel[GNT_NRT];
                end
                ARB_BUSY: if (tx_done) begin
                    state   <= ARB_IDLE;
                    grant_q <= '0;
                end
                default: state <= ARB_IDLE;
            endcase
        end
    end

    assign grant       = grant_q;
    assign start_pulse = start_q;
endmodule

// File: rtl/qos_tx_arbiter_chk.sv
module qos_tx_arbiter_chk (
    input logic       clk,
    input logic       rst,
    input logic       qos_en,
    input logic       rt_req,
    input logic       nrt_req,
    input logic       tx_done,
    input logic       blocked,
    input logic       aged,
    input logic [1:0] grant,
    input logic       start_pulse
);
    // R2: grant never has both bits set
    a_r2_grant_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant));

    // R2: start strobe lasts one cycle
    a_r2_start_single: assert property (@(posedge clk) disable iff (rst)
        start_pulse |=> !start_pulse);

    // R2: grant holds until completion is reported
    a_r2_grant_hold: assert property (@(posedge clk) disable iff (rst)
        (grant != 2'b00 && !tx_done) |=> grant == $past(grant));

    // R10: a start only follows an idle cycle, never pre-empts
    a_r10_no_preempt: assert property (@(posedge clk) disable iff (rst)
        start_pulse |-> ($past(grant) == 2'b00 && grant != 2'b00));

    // R5 / R8: low-priority start inside the guard interval only when aged
    a_r5_block_respected: assert property (@(posedge clk) disable iff (rst)
        (start_pulse && grant[1]) |-> !$past(qos_en && blocked && !aged));

    // R11: grants only go to requesting queues
    a_r11_rt_requested: assert property (@(posedge clk) disable iff (rst)
        (start_pulse && grant[0]) |-> $past(rt_req));
    a_r11_nrt_requested: assert property (@(posedge clk) disable iff (rst)
        (start_pulse && grant[1]) |-> $past(nrt_req));
endmodule

bind qos_tx_arbiter qos_tx_arbiter_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .qos_en     (qos_en),
    .rt_req     (rt_req),
    .nrt_req    (nrt_req),
    .tx_done    (tx_done),
    .blocked    (blocked_w),
    .aged       (aged_w),
    .grant      (grant),
    .start_pulse(start_pulse)
);

// File: tb/sim_qos_tx_arbiter.sv
module sim_qos_tx_arbiter;
    localparam int CLK_PERIOD = 10;
    localparam logic [1:0] G_RT  = 2'b01;
    localparam logic [1:0] G_NRT = 2'b10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        qos_en = 1'b0;
    logic        rt_req = 1'b0;
    logic        nrt_req = 1'b0;
    logic        tx_done = 1'b0;
    logic [15:0] tx_time = '0;
    logic [15:0] lead = 16'd1000;
    logic [15:0] rt_launch;
    logic [15:0] block_zone = '0;
    logic [15:0] age_limit = 16'd1000;
    logic [1:0]  grant;
    logic        start_pulse;

    int tests = 0;
    int fails = 0;
    logic [1:0] exp_q[$];
    string      tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(negedge clk) tx_time <= tx_time + 16'd1;
    assign rt_launch = tx_time + lead;

    qos_tx_arbiter u0 (
        .clk(clk), .rst(rst), .qos_en(qos_en), .rt_req(rt_req), .nrt_req(nrt_req),
        .tx_done(tx_done), .tx_time(tx_time), .rt_launch(rt_launch),
        .block_zone(block_zone), .age_limit(age_limit),
        .grant(grant), .start_pulse(start_pulse)
    );

    task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Monitor: every start must match the next expected grant
    always @(negedge clk) begin
        if (!rst && start_pulse) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R11 unexpected start", {14'd0, grant}, 16'd0);
            end else begin
                logic [1:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(grant == e, t, {14'd0, grant}, {14'd0, e});
            end
        end
    end

    // Driver: queue the expected winner, wait for its start, hold, complete
    task automatic serve(input logic [1:0] exp, input int busy, input string tag);
        int starts = 0;
        int changes = 0;
        bit seen = 0;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        for (int i = 0; i < 400 && !seen; i++) begin
            @(negedge clk);
            seen = start_pulse;
        end
        chk(seen, {tag, " start seen"}, {15'd0, seen}, 16'd1);
        for (int i = 0; i < busy; i++) begin
            @(negedge clk);
            if (start_pulse) starts++;
            if (grant != exp) changes++;
        end
        chk(starts == 0 && changes == 0, "R10 no new start while busy",
            16'(starts + changes), 16'd0);
        tx_done = 1'b1;
        @(negedge clk);
        tx_done = 1'b0;
        chk(grant == 2'b00, "R2 grant drops after done", {14'd0, grant}, 16'd0);
    endtask

    task automatic expect_quiet(input int cycles, input string tag);
        int starts = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (start_pulse || grant != 2'b00) starts++;
        end
        chk(starts == 0, tag, 16'(starts), 16'd0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        chk(1'b0, "watchdog expired", 16'd0, 16'd1);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin : stim
        repeat (3) @(negedge clk);
        chk(grant == 2'b00 && start_pulse == 1'b0, "R1 reset outputs",
            {13'd0, start_pulse, grant}, 16'd0);
        rst = 1'b0;
        @(negedge clk);
        chk(grant == 2'b00, "R1 idle after reset", {14'd0, grant}, 16'd0);

        // R11: nothing requested, nothing starts
        expect_quiet(10, "R11 no request no start");

        // R3: plain mode, guard active and ageing at zero would matter in QoS mode
        qos_en = 1'b0; block_zone = 16'd100; lead = 16'd2; age_limit = 16'd0;
        rt_req = 1'b1; nrt_req = 1'b1;
        serve(G_RT,  3, "R3 alternate first rt");
        serve(G_NRT, 3, "R3 alternate nrt despite guard");
        serve(G_RT,  3, "R3 alternate rt despite ageing");
        serve(G_NRT, 3, "R3 alternate nrt");
        rt_req = 1'b0; nrt_req = 1'b0;
        expect_quiet(5, "R11 quiet after requests drop");

        // R4 / R6: QoS on, guard disabled, long ageing
        qos_en = 1'b1; block_zone = 16'd0; lead = 16'd2; age_limit = 16'd1000;
        rt_req = 1'b1; nrt_req = 1'b1;
        serve(G_RT, 4, "R4 rt beats fresh nrt");
        serve(G_RT, 4, "R4 rt beats fresh nrt again");
        rt_req = 1'b0;
        serve(G_NRT, 4, "R6 zero zone never blocks");
        nrt_req = 1'b0;
        @(negedge clk);

        // R5: guard interval and its boundary
        block_zone = 16'd50; lead = 16'd10;
        nrt_req = 1'b1;
        expect_quiet(30, "R5 nrt held inside guard");
        lead = 16'd49;
        expect_quiet(20, "R5 nrt held at distance zone-1");
        lead = 16'd50;
        serve(G_NRT, 4, "R5 nrt starts at distance equal to zone");
        nrt_req = 1'b0;
        @(negedge clk);

        // R7: ageing beats real-time traffic
        block_zone = 16'd0; age_limit = 16'd2;
        rt_req = 1'b1; nrt_req = 1'b1;
        serve(G_RT, 160, "R7 rt first while nrt young");
        serve(G_NRT, 4, "R7 aged nrt beats rt");
        age_limit = 16'd3;
        serve(G_RT, 100, "R7 reloaded wait not yet expired");
        serve(G_RT, 120, "R7 still below limit at grant");
        serve(G_NRT, 4, "R7 expired after limit times 64");
        rt_req = 1'b0; nrt_req = 1'b0;
        @(negedge clk);

        // R9: zero limit promotes at once
        age_limit = 16'd0;
        rt_req = 1'b1; nrt_req = 1'b1;
        serve(G_NRT, 4, "R9 zero limit immediate promotion");
        nrt_req = 1'b0;
        serve(G_RT, 4, "R9 rt after nrt leaves");
        rt_req = 1'b0;
        @(negedge clk);

        // R8: aged nrt overrides guard interval
        block_zone = 16'd50; lead = 16'd10; age_limit = 16'd0;
        rt_req = 1'b1; nrt_req = 1'b1;
        serve(G_NRT, 4, "R8 aged nrt overrides guard");
        rt_req = 1'b0; nrt_req = 1'b0;
        expect_quiet(5, "R11 final quiet");

        chk(exp_q.size() == 0, "R2 all expected starts seen", 16'(exp_q.size()), 16'd0);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule